// File: doc/BRIEF.md
# Phase-accumulator paced serial transmitter

This block takes bytes from a FIFO and shifts them out on one serial line. It pops a byte through a single-cycle strobe, then sends a start bit, the eight data bits starting with the least significant, an optional parity bit, and a stop bit.

The bit rate comes from a 16-bit phase accumulator. The accumulator adds a programmable increment on every clock, and each carry out of it is one oversampling tick. Each bit lasts sixteen ticks, so the line rate is the increment times the clock frequency divided by 2^20.

The transmitter accepts new bytes only while its enable input is high. Parity is selected per frame, at the moment the byte is popped.

Top module: `nco_uart_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `tx_line` is high, `tx_busy` is low and `tx_pop` is low.
- R2: `tx_pop` is high for exactly one cycle, and only while the transmitter is idle with `tx_en` and `tx_valid` both high. `tx_busy` is high in the cycle after a pop, and no pop occurs while `tx_busy` is high.
- R3: A frame starts with one low bit. The eight data bits follow with bit 0 first, and the frame ends with a high stop bit.
- R4: Each bit lasts 16 ticks. A tick is a carry out of a 16-bit accumulator that adds `nco_inc` every clock. For `nco_inc` = 2^k, each bit therefore lasts exactly 2^(20-k) clock cycles.
- R5: When `par_en` is high at the pop, one parity bit goes between the last data bit and the stop bit, giving 11 bits. The parity bit is the XOR of the eight data bits when `par_odd` is low, and its inverse when `par_odd` is high.
- R6: While `tx_en` is low, no byte is popped and the line stays high, even with `tx_valid` held high.
- R7: If `tx_en` is cleared during a frame, that frame completes intact. No further byte is popped until `tx_en` is set again.
- R8: With `nco_inc` equal to zero there are no ticks and `tx_line` does not change. A byte already popped waits with `tx_busy` high and is sent once the increment becomes non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| nco_inc | input | 16 | Phase accumulator increment |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | Odd parity when high, even when low |
| tx_data | input | 8 | Byte at the FIFO head |
| tx_valid | input | 1 | FIFO holds a byte |
| tx_line | output | 1 | Serial output, idles high |
| tx_pop | output | 1 | Removes the head byte from the FIFO |
| tx_busy | output | 1 | A frame is pending or being sent |

## Verification
The assertions assume that `tx_en`, `tx_valid` and `tx_data` change only between clock edges, and that the FIFO drops its head byte exactly when `tx_pop` is seen. They also assume that `nco_inc` changes only while the line is idle or while it is zero.

The stimulus meets these assumptions in three ways:
- It drives inputs on the falling clock edge.
- It holds a byte until the pop strobe appears and withdraws it after the consuming edge.
- It changes the increment and parity settings only after the bench decoder has drained every expected byte, except in the zero-increment case.

Increments are powers of two, so the bench can predict the bit time exactly.

// File: rtl/nco_uart_tx.sv
module nco_uart_tx #(
  parameter int NCO_W    = 16,
  parameter int DATA_W   = 8,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [NCO_W-1:0]  nco_inc,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_line,
  output logic              tx_pop,
  output logic              tx_busy
);
  localparam int FRM_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRM_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} st_t;

  st_t                 st;
  logic [NCO_W-1:0]    acc;
  logic [NCO_W:0]      sum;
  logic                tick;
  logic [OVS_LOG2-1:0] ovs;
  logic [FRM_W-1:0]    frm;
  logic [CNT_W-1:0]    left;
  logic                bit_end;
  logic                par_bit;

  assign sum     = {1'b0, acc} + {1'b0, nco_inc};
  assign tick    = sum[NCO_W];
  assign bit_end = tick && (&ovs);
  assign par_bit = par_en ? ((^tx_data) ^ par_odd) : 1'b1;
  assign tx_pop  = (st == S_IDLE) && tx_en && tx_valid;
  assign tx_busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else        acc <= sum[NCO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tx_line <= 1'b1;
      ovs     <= '0;
      frm     <= '1;
      left    <= '0;
    end else begin
      case (st)
        S_IDLE: if (tx_pop) begin
          frm  <= {1'b1, par_bit, tx_data, 1'b0};
          left <= par_en ? CNT_W'(FRM_W) : CNT_W'(FRM_W - 1);
          st   <= S_WAIT;
        end
        S_WAIT: if (tick) begin
          tx_line <= frm[0];
          frm     <= {1'b1, frm[FRM_W-1:1]};
          left    <= left - 1'b1;
          ovs     <= '0;
          st      <= S_SEND;
        end
        S_SEND: if (tick) begin
          ovs <= ovs + 1'b1;
          if (bit_end) begin
            if (left == '0) st <= S_IDLE;
            else begin
              tx_line <= frm[0];
              frm     <= {1'b1, frm[FRM_W-1:1]};
              left    <= left - 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nco_uart_tx_chk #(parameter int NCO_W = 16) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCO_W-1:0] nco_inc,
  input logic             tx_line,
  input logic             tx_pop,
  input logic             tx_busy
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);
  assert_pop_then_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> (tx_busy && !tx_pop));
  assert_no_pop_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_pop);
  assert_start_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_line) |-> tx_busy);
  assert_end_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> tx_line);
  assert_zero_rate_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nco_inc == '0) |=> $stable(tx_line));
endmodule

bind nco_uart_tx nco_uart_tx_chk #(.NCO_W(NCO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nco_inc(nco_inc),
  .tx_line(tx_line), .tx_pop(tx_pop), .tx_busy(tx_busy));

// File: tb/sim_nco_uart_tx.sv
module sim_nco_uart_tx;
  logic clk = 0, rst_n = 0, tx_en = 0, par_en = 0, par_odd = 0, tx_valid = 0;
  logic [15:0] nco_inc = 0;
  logic [7:0]  tx_data = 0;
  logic tx_line, tx_pop, tx_busy;

  always #4 clk = ~clk;

  nco_uart_tx u0 (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .nco_inc(nco_inc),
    .par_en(par_en), .par_odd(par_odd), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_line(tx_line), .tx_pop(tx_pop), .tx_busy(tx_busy));

  int n_chk = 0, n_err = 0, cyc = 0;
  int per = 2;
  logic [7:0] exp_q [0:255];
  int wr = 0, rd = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit par_of(logic [7:0] d, bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  // serial decoder
  initial begin
    logic prev;
    prev = 1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx_line) begin
        int nb, lowrun, bp;
        bit stillow;
        logic [7:0] d, ex;
        bit pe, po, pb, sb;
        pe = par_en; po = par_odd; bp = 16 * per;
        nb = pe ? 11 : 10;
        lowrun = 1; stillow = 1; d = 0; pb = 0; sb = 0;
        for (int c = 1; c <= bp * (nb - 1) + bp / 2; c++) begin
          @(negedge clk);
          if (stillow && !tx_line) lowrun++;
          else stillow = 0;
          for (int i = 1; i <= 8; i++)
            if (c == bp * i + bp / 2) d[i-1] = tx_line;
          if (pe && c == bp * 9 + bp / 2) pb = tx_line;
          if (c == bp * (nb - 1) + bp / 2) sb = tx_line;
        end
        ex = exp_q[rd[7:0]];
        check(rd < wr, "R3 frame without pop", rd, wr);
        check(d == ex, "R3 data bits", d, ex);
        check(sb == 1'b1, "R3 stop bit", sb, 1);
        if (ex[0]) check(lowrun == bp, "R4 start bit length", lowrun, bp);
        if (pe) check(pb == par_of(ex, po), "R5 parity bit", pb, par_of(ex, po));
        rd++;
      end
      prev = tx_line;
    end
  end

  task automatic offer(logic [7:0] b);
    tx_data = b; tx_valid = 1;
    #1;
    while (!tx_pop) begin @(negedge clk); #1; end
    exp_q[wr[7:0]] = b; wr++;
    @(negedge clk);
    tx_valid = 0;
    check(tx_busy && !tx_pop, "R2 busy after pop", tx_busy, 1);
  endtask

  task automatic drain();
    while (rd < wr || tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic segment(int k, bit pe, bit po, int n);
    nco_inc = 16'(1 << k); per = 1 << (16 - k); par_en = pe; par_odd = po;
    for (int i = 0; i < n; i++) begin
      offer(8'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();
  endtask

  initial begin
    int pops;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1 && tx_busy === 1'b0 && tx_pop === 1'b0, "R1 reset state",
          {tx_line, tx_busy, tx_pop}, 3'b100);
    rst_n = 1;
    tx_en = 1;
    // directed bytes with edge patterns
    nco_inc = 16'h8000; per = 2;
    offer(8'h00); offer(8'hFF); offer(8'hA5); offer(8'h01);
    drain();
    check(tx_line && !tx_busy, "R1 idle after frames", tx_line, 1);
    segment(15, 0, 0, 8);
    segment(14, 1, 0, 6);
    segment(13, 1, 1, 5);
    segment(12, 0, 0, 3);
    for (int s = 0; s < 4; s++)
      segment(13 + int'($urandom % 3), 1'($urandom), 1'($urandom), 4);

    // R6: disabled transmitter
    nco_inc = 16'h8000; per = 2;
    tx_en = 0; tx_data = 8'h3C; tx_valid = 1; pops = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx_pop || !tx_line) pops++;
    end
    check(pops == 0, "R6 disabled no pop, line high", pops, 0);
    tx_valid = 0;

    // R7: disable during a frame
    tx_en = 1;
    offer(8'h5A);
    while (tx_line) @(negedge clk);
    tx_en = 0; tx_data = 8'hC3; tx_valid = 1; pops = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (tx_pop) pops++;
    end
    check(pops == 0, "R7 no pop after disable", pops, 0);
    check(rd == wr && !tx_busy, "R7 frame completed", rd, wr);
    tx_en = 1;
    offer(8'hC3);
    drain();

    // R8: zero increment
    nco_inc = 0;
    offer(8'h96);
    pops = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!tx_line) pops++;
    end
    check(pops == 0, "R8 line still with zero rate", pops, 0);
    check(tx_busy == 1'b1, "R8 byte pending", tx_busy, 1);
    nco_inc = 16'h4000; per = 4;
    drain();
    check(rd == wr, "R8 pending byte sent", rd, wr);

    done = 1;
    finish_run();
  end
endmodule